// File: doc/BRIEF.md
# Double-Buffered Serial Receiver

This block is the receive half of a programmable serial port. It watches one serial input line at the instants marked by a receive-clock enable. It builds each incoming character in a shift register, then moves the finished character into a holding register where the CPU can pick it up. Because there are two registers, the next character can arrive while the previous one waits. If a character is still unread when the next one completes, the unread one is replaced and an overrun flag is raised.

Two framing modes are available. In asynchronous mode the receive clock runs at 1, 16 or 64 times the bit rate. The receiver finds the falling edge of a start bit, confirms it at mid-bit when oversampling, and samples each data bit and the stop bit at the centre of its bit period. In synchronous mode every receive-clock tick carries one bit. The receiver first hunts for one fixed sync byte, then cuts the stream into characters.

The CPU reads through one port. A select input picks either the holding register or a status word. Reading the data clears the ready output. A clear command removes the error flags.

Top module: `usart_rx`

## Requirements
- R1: In asynchronous mode, a frame made of a low start bit, DATA_W data bits sent least significant bit first and a stop bit is placed in the holding register. `rx_rdy` then goes high, and a data read returns the character.
- R2: `rate_sel` encodes 2'b01 as 1x, 2'b10 as 16x and 2'b11 as 64x, with a factor D. Data bit k is sampled D/2 + D·(k+1) ticks after the tick that first sees the line low. At 1x it is sampled k+1 ticks after that tick.
- R3: At 16x or 64x, a line that is high again at the mid-bit confirmation tick (D/2 ticks after the first low sample) is dropped as a glitch. No character is produced, and a later valid frame is still received.
- R4: A read with `sel_status`=0 clears `rx_rdy` one cycle later. A read with `sel_status`=1 leaves `rx_rdy` unchanged.
- R5: If a character completes while `rx_rdy` is high and no data read happens in the same cycle, the holding register takes the new character and status bit 1 (overrun) is set.
- R6: A low level sampled at the stop-bit centre sets status bit 2 (framing error). The character is still delivered.
- R7: A one-cycle pulse on `clr_err` clears status bits 1 and 2. It leaves `rx_rdy` and the holding register unchanged.
- R8: With `rate_sel`=2'b00 (synchronous), one bit is shifted in per tick until the last DATA_W bits, least significant bit first, equal SYNC_PAT. Status bit 3 (locked) is then set, and each following group of DATA_W ticks delivers one character.
- R9: A low `rst_n` at a clock edge clears `rx_rdy`, all status bits and the holding register.
- R10: With `sel_status`=1, `rd_data` shows the status word: bit 0 ready, bit 1 overrun, bit 2 framing error, bit 3 locked, and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | One-cycle enable marking each receive-clock tick |
| rate_sel | input | 2 | Mode: 00 sync, 01 async 1x, 10 async 16x, 11 async 64x |
| rx_line | input | 1 | Serial input line; idle high |
| rd_en | input | 1 | CPU read strobe |
| sel_status | input | 1 | 1 selects the status word, 0 selects received data |
| clr_err | input | 1 | Command pulse clearing overrun and framing flags |
| rx_rdy | output | 1 | A character is waiting in the holding register |
| rd_data | output | DATA_W | Holding register or status word |

## Verification
A vector table sends characters at all three asynchronous rates, with data patterns that include all-zeros, all-ones and alternating bits. A mistake in bit order, in the sample point or in the divisor selection therefore shows up as a different byte. One vector carries a low stop bit, which separates a framing error from a clean frame. A start pulse shorter than half a bit tells real glitch rejection apart from plain edge triggering. In synchronous mode, a leading run of zeros before the sync byte shows that lock occurs only on the exact pattern. Two back-to-back unread characters then separate overwrite with overrun from a receiver that keeps the first character.

// File: rtl/usart_rx_pkg.sv
// Package: shared encodings for the serial receiver.
// Assumes: status word is at least 4 bits wide.
package usart_rx_pkg;

    typedef enum logic [1:0] {
        RATE_SYNC = 2'b00,
        RATE_X1   = 2'b01,
        RATE_X16  = 2'b10,
        RATE_X64  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_START,
        AS_DATA,
        AS_STOP
    } async_st_e;

    localparam int ST_RDY  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_FE   = 2;
    localparam int ST_LOCK = 3;

endpackage

// File: rtl/rx_line_sync.sv
// Module: brings the asynchronous serial line into the clk domain.
// Assumes: STAGES >= 2; line idles high, so reset value is high.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    // Shift the raw line through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_async_frame.sv
// Module: asynchronous frame engine. Detects the start bit, confirms it at
// mid-bit when oversampling, and samples data and stop bits at bit centres.
// Assumes: rate stays constant while a frame is in progress; en low holds
// the engine idle.
module rx_async_frame
    import usart_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MID_DIV  = 16,
    parameter int HIGH_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [1:0]        rate,
    input  logic              line,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              char_fe
);
    localparam int CNT_W = $clog2(HIGH_DIV + 1);
    localparam int IDX_W = $clog2(DATA_W + 1);

    async_st_e         st;
    logic [CNT_W-1:0]  cnt, cnt_nx, div, half;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;

    // Pick the tick count per bit from the rate selection.
    always_comb begin
        case (rate)
            RATE_X16: div = CNT_W'(MID_DIV);
            RATE_X64: div = CNT_W'(HIGH_DIV);
            default:  div = CNT_W'(1);
        endcase
        half   = div >> 1;
        cnt_nx = cnt + 1'b1;
    end

    // Frame state machine advancing on receive ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st         <= AS_IDLE;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            char_valid <= 1'b0;
            char_data  <= '0;
            char_fe    <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                case (st)
                    AS_IDLE: begin
                        if (!line) begin
                            st  <= (div == CNT_W'(1)) ? AS_DATA : AS_START;
                            cnt <= '0;
                            idx <= '0;
                        end
                    end
                    AS_START: begin
                        if (cnt_nx == half) begin
                            cnt <= '0;
                            st  <= line ? AS_IDLE : AS_DATA;
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                    AS_DATA: begin
                        if (cnt_nx == div) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                            if (idx == IDX_W'(DATA_W - 1)) st <= AS_STOP;
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                    default: begin
                        if (cnt_nx == div) begin
                            cnt        <= '0;
                            st         <= AS_IDLE;
                            char_valid <= 1'b1;
                            char_data  <= shreg;
                            char_fe    <= !line;
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                endcase
            end
        end
    end

    // Bit index never runs past the character width while collecting data.
    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == AS_DATA) |-> (idx < DATA_W));

    // A finished character is reported for a single cycle only.
    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // A glitch rejection returns to idle without producing a character.
    assert_glitch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (st == AS_START && tick && cnt_nx == half && line) |=> !char_valid);
endmodule

// File: rtl/rx_sync_frame.sv
// Module: synchronous frame engine. One bit per tick; hunts for a fixed
// sync pattern, then delivers a character every DATA_W ticks.
// Assumes: lock is kept until reset or leaving synchronous mode.
module rx_sync_frame #(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] SYNC_PAT = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              line,
    output logic              locked,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] win, win_nx;
    logic [IDX_W-1:0]  cnt;

    assign win_nx = {line, win[DATA_W-1:1]};

    // Shift the window, detect the sync pattern, then frame characters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            win        <= '0;
            cnt        <= '0;
            locked     <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                win <= win_nx;
                if (!locked) begin
                    if (win_nx == SYNC_PAT) begin
                        locked <= 1'b1;
                        cnt    <= '0;
                    end
                end else if (cnt == IDX_W'(DATA_W - 1)) begin
                    char_valid <= 1'b1;
                    char_data  <= win_nx;
                    cnt        <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Once locked, lock persists while the engine stays enabled.
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
        locked |=> locked);

    // Characters are only produced after lock.
    assert_char_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> locked);
endmodule

// File: rtl/rx_hold_regs.sv
// Module: holding register plus ready, overrun and framing flags.
// Assumes: ld is a one-cycle pulse per completed character.
module rx_hold_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_fe,
    input  logic              rd_take,
    input  logic              clr_err,
    output logic [DATA_W-1:0] hold,
    output logic              rdy,
    output logic              ovr,
    output logic              fe
);
    // Load a new character or release it on a CPU data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            rdy  <= 1'b0;
        end else if (ld) begin
            hold <= ld_data;
            rdy  <= 1'b1;
        end else if (rd_take) begin
            rdy <= 1'b0;
        end
    end

    // Error flags: set on event, cleared by command; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            fe  <= 1'b0;
        end else begin
            if (ld && rdy && !rd_take) ovr <= 1'b1;
            else if (clr_err)          ovr <= 1'b0;
            if (ld && ld_fe)           fe  <= 1'b1;
            else if (clr_err)          fe  <= 1'b0;
        end
    end

    assert_load_sets_rdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> rdy);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !ld) |=> !rdy);

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && rdy && !rd_take) |=> ovr);

    assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !ld) |=> (!ovr && !fe));

    assert_clear_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !ld && !rd_take) |=> ($stable(hold) && $stable(rdy)));

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!rdy && !ovr && !fe && hold == '0));
endmodule

// File: rtl/usart_rx.sv
// Module: top of the double-buffered serial receiver. Synchronizes the line,
// runs the asynchronous or synchronous frame engine chosen by rate_sel, and
// presents holding register or status to the CPU.
// Assumes: rate_sel changes only while the line is idle; DATA_W >= 4.
module usart_rx
    import usart_rx_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                MID_DIV     = 16,
    parameter int                HIGH_DIV    = 64,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] SYNC_PAT    = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_tick,
    input  logic [1:0]        rate_sel,
    input  logic              rx_line,
    input  logic              rd_en,
    input  logic              sel_status,
    input  logic              clr_err,
    output logic              rx_rdy,
    output logic [DATA_W-1:0] rd_data
);
    logic              line_s;
    logic              async_en, sync_en;
    logic              a_valid, a_fe, s_valid, s_locked;
    logic [DATA_W-1:0] a_data, s_data;
    logic              ld, ld_fe, rd_take;
    logic [DATA_W-1:0] ld_data, hold, status_w;
    logic              ovr, fe;

    assign async_en = (rate_sel != RATE_SYNC);
    assign sync_en  = !async_en;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    rx_async_frame #(.DATA_W(DATA_W), .MID_DIV(MID_DIV), .HIGH_DIV(HIGH_DIV)) u_async (
        .clk(clk), .rst_n(rst_n), .en(async_en), .tick(rx_tick), .rate(rate_sel),
        .line(line_s), .char_valid(a_valid), .char_data(a_data), .char_fe(a_fe)
    );

    rx_sync_frame #(.DATA_W(DATA_W), .SYNC_PAT(SYNC_PAT)) u_sframe (
        .clk(clk), .rst_n(rst_n), .en(sync_en), .tick(rx_tick), .line(line_s),
        .locked(s_locked), .char_valid(s_valid), .char_data(s_data)
    );

    // Merge the two engines into one load request for the holding stage.
    always_comb begin
        ld      = a_valid | s_valid;
        ld_data = a_valid ? a_data : s_data;
        ld_fe   = a_valid & a_fe;
        rd_take = rd_en & !sel_status;
    end

    rx_hold_regs #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_data(ld_data), .ld_fe(ld_fe),
        .rd_take(rd_take), .clr_err(clr_err), .hold(hold), .rdy(rx_rdy),
        .ovr(ovr), .fe(fe)
    );

    // Assemble the status word and select the CPU read value.
    always_comb begin
        status_w          = '0;
        status_w[ST_RDY]  = rx_rdy;
        status_w[ST_OVR]  = ovr;
        status_w[ST_FE]   = fe;
        status_w[ST_LOCK] = s_locked;
        rd_data           = sel_status ? status_w : hold;
    end

    // The engines never deliver a character in the same cycle.
    assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_valid && s_valid));
endmodule

// File: tb/usart_rx_tb.sv
module usart_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic [1:0] rate_sel = 2'b01;
    logic       rx_line = 1'b1;
    logic       rd_en = 1'b0;
    logic       sel_status = 1'b0;
    logic       clr_err = 1'b0;
    logic       rx_rdy;
    logic [7:0] rd_data;
    int         total = 0;
    int         bad = 0;
    logic [7:0] v;

    always #2 clk = ~clk;

    usart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rate_sel(rate_sel),
        .rx_line(rx_line), .rd_en(rd_en), .sel_status(sel_status),
        .clr_err(clr_err), .rx_rdy(rx_rdy), .rd_data(rd_data)
    );

    // {rate, byte, stop level}
    localparam logic [10:0] VEC [0:5] = '{
        {2'b01, 8'hA5, 1'b1},
        {2'b10, 8'h3C, 1'b1},
        {2'b11, 8'h81, 1'b1},
        {2'b10, 8'h00, 1'b1},
        {2'b01, 8'hFF, 1'b1},
        {2'b10, 8'h5A, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick_once();
        repeat (3) @(negedge clk);
        rx_tick = 1'b1;
        @(negedge clk);
        rx_tick = 1'b0;
    endtask

    task automatic ticks(input int n, input logic lvl);
        rx_line = lvl;
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic send_frame(input logic [1:0] r, input logic [7:0] b, input logic stop);
        int d;
        d = (r == 2'b01) ? 1 : (r == 2'b10) ? 16 : 64;
        rate_sel = r;
        ticks(d, 1'b0);
        for (int i = 0; i < 8; i++) ticks(d, b[i]);
        ticks(d, stop);
        ticks(2 * d, 1'b1);
    endtask

    task automatic sync_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) ticks(1, b[i]);
    endtask

    task automatic cpu_read(input logic s, output logic [7:0] val);
        @(negedge clk);
        sel_status = s;
        rd_en = 1'b1;
        #1 val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        sel_status = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R9 R10: reset state
        @(negedge clk);
        chk("R9 rx_rdy", {31'b0, rx_rdy}, 0);
        cpu_read(1'b1, v); chk("R9 R10 status", {24'b0, v}, 0);
        cpu_read(1'b0, v); chk("R9 data", {24'b0, v}, 0);

        // Vector table: R1 R2 R6 R10 R4 R7
        foreach (VEC[k]) begin
            send_frame(VEC[k][10:9], VEC[k][8:1], VEC[k][0]);
            chk("R1 R2 rx_rdy", {31'b0, rx_rdy}, 1);
            cpu_read(1'b1, v);
            chk("R6 R10 status", {24'b0, v}, {29'b0, !VEC[k][0], 2'b01});
            cpu_read(1'b0, v);
            chk("R1 R2 data", {24'b0, v}, {24'b0, VEC[k][8:1]});
            chk("R4 rdy after read", {31'b0, rx_rdy}, 0);
            do_clear();
            cpu_read(1'b1, v);
            chk("R7 status after clear", {24'b0, v}, 0);
        end

        // R3: short low pulse rejected, then a real frame accepted
        rate_sel = 2'b10;
        ticks(4, 1'b0);
        ticks(40, 1'b1);
        chk("R3 glitch rx_rdy", {31'b0, rx_rdy}, 0);
        cpu_read(1'b1, v); chk("R3 glitch status", {24'b0, v}, 0);
        send_frame(2'b10, 8'h96, 1'b1);
        cpu_read(1'b1, v); chk("R3 R4 status read keeps rdy", {24'b0, v}, 1);
        chk("R4 rdy after status read", {31'b0, rx_rdy}, 1);
        cpu_read(1'b0, v); chk("R3 data after glitch", {24'b0, v}, 8'h96);
        chk("R4 rdy cleared", {31'b0, rx_rdy}, 0);

        // R5 R7: async overrun then clear
        send_frame(2'b01, 8'h11, 1'b1);
        send_frame(2'b01, 8'h22, 1'b1);
        cpu_read(1'b1, v); chk("R5 overrun status", {24'b0, v}, 8'h03);
        do_clear();
        cpu_read(1'b1, v); chk("R7 clear keeps rdy", {24'b0, v}, 8'h01);
        cpu_read(1'b0, v); chk("R5 R7 newest data kept", {24'b0, v}, 8'h22);

        // R8: synchronous hunt and framing
        rate_sel = 2'b00;
        rx_line = 1'b0;
        do_reset();
        ticks(4, 1'b0);
        cpu_read(1'b1, v); chk("R8 not locked on zeros", {24'b0, v}, 0);
        sync_byte(8'h7E);
        repeat (2) @(negedge clk);
        cpu_read(1'b1, v); chk("R8 locked", {24'b0, v}, 8'h08);
        sync_byte(8'hC3);
        repeat (2) @(negedge clk);
        cpu_read(1'b1, v); chk("R8 first char ready", {24'b0, v}, 8'h09);
        sync_byte(8'h2D);
        repeat (2) @(negedge clk);
        cpu_read(1'b1, v); chk("R5 R8 sync overrun", {24'b0, v}, 8'h0B);
        cpu_read(1'b0, v); chk("R8 sync data", {24'b0, v}, 8'h2D);

        // R9: reset mid-operation clears everything
        sync_byte(8'hE7);
        repeat (2) @(negedge clk);
        do_reset();
        @(negedge clk);
        cpu_read(1'b1, v); chk("R9 status after reset", {24'b0, v}, 0);
        cpu_read(1'b0, v); chk("R9 data after reset", {24'b0, v}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule